// File: doc/BRIEF.md
# Parallel Port Abort Guard

This block sits between the host-side SELECTIN line of a bidirectional parallel port and the logic that drives the eight data lines back toward the host. It brings the asynchronous SELECTIN pin into the clock domain through a two-stage synchronizer. When enabled, a digital filter follows, so short glitches are dropped. The conditioned level is held in a status bit that software can read. Every internal decision uses that status bit, never the raw pin.

When abort protection is on and the conditioned SELECTIN is low, the host has left a reverse transfer. The block then clears the data-enable bit, turns off the data drivers at once, and refuses CPU writes that try to set the bit again. The block also chooses the source of the BUSY and ACK pins: software bits or the handshake machine. It drives the SELECT and FAULT pins straight from their control bits. The transfer state machine itself is outside this block.

Top module: `pp_abort_guard`

## Requirements
- R1: With the filter disabled, `selin_stat` equals the level `selin_raw` had three rising edges earlier (two synchronizer flops plus the status register).
- R2: With the filter enabled, `selin_stat` changes only after three consecutive identical synchronized samples. A change held steady on `selin_raw` appears six rising edges later. A pulse lasting two clocks or less never reaches `selin_stat`.
- R3: When `abort_en` is 1 and `selin_stat` is 0 at a rising edge, `data_en` is 0 after that edge.
- R4: `pd_oe` (1 = drive the data bus, 0 = tristate) is 0 whenever `data_en` is 0. It is also 0 in the same cycle whenever `abort_en` is 1 and `selin_stat` is 0.
- R5: A write (`de_wr`=1, `de_wdata`=1) that occurs while `abort_en` is 1 and `selin_stat` is 0 leaves `data_en` at 0. A low `selin_stat` has no effect on `data_en` while `abort_en` is 0.
- R6: In every other case, a write with `de_wr`=1 loads `de_wdata` into `data_en` at the next rising edge. With `de_wr`=0, `data_en` holds its value.
- R7: When `hs_en`=0 and `hs_idle`=1, `busy_pin` and `ack_pin` equal `sw_busy` and `sw_ack`. In all other cases they equal `hs_busy` and `hs_ack`.
- R8: `sel_pin` equals `sw_sel` and `fault_pin` equals `sw_fault`, with no delay.
- R9: During and right after reset, `data_en`=0, `pd_oe`=0 and `selin_stat`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| selin_raw | input | 1 | Asynchronous SELECTIN pin from the host |
| filt_en | input | 1 | Digital filter enable |
| abort_en | input | 1 | Abort protection enable |
| de_wr | input | 1 | CPU write strobe for the data-enable bit |
| de_wdata | input | 1 | Value written to the data-enable bit |
| sw_busy | input | 1 | Software BUSY control bit |
| sw_ack | input | 1 | Software ACK control bit |
| sw_sel | input | 1 | SELECT control bit |
| sw_fault | input | 1 | FAULT control bit |
| hs_en | input | 1 | Hardware handshaking enabled |
| hs_idle | input | 1 | Handshake machine is idle |
| hs_busy | input | 1 | BUSY value from the handshake machine |
| hs_ack | input | 1 | ACK value from the handshake machine |
| selin_stat | output | 1 | Conditioned SELECTIN status bit |
| data_en | output | 1 | Data-enable bit |
| pd_oe | output | 1 | Data bus driver enable (0 = tristate) |
| busy_pin | output | 1 | BUSY pin |
| ack_pin | output | 1 | ACK pin |
| sel_pin | output | 1 | SELECT pin |
| fault_pin | output | 1 | FAULT pin |

## Verification
If the synchronizer or filter state is wrong, `selin_stat` changes on the wrong edge. With the filter off, the correct edge is exactly three after the pin changes; with it on, six. A wrong filter can also let a two-clock pulse through. A `data_en` register that misses the abort condition shows up one edge later, as `data_en` still at 1. A missing gate on `pd_oe` shows up in the same cycle. A write that gets past protection shows up as `data_en` at 1 one edge after the write.

// File: rtl/pp_abort_guard.sv
module pp_abort_guard #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic selin_raw,
  input  logic filt_en,
  input  logic abort_en,
  input  logic de_wr,
  input  logic de_wdata,
  input  logic sw_busy,
  input  logic sw_ack,
  input  logic sw_sel,
  input  logic sw_fault,
  input  logic hs_en,
  input  logic hs_idle,
  input  logic hs_busy,
  input  logic hs_ack,
  output logic selin_stat,
  output logic data_en,
  output logic pd_oe,
  output logic busy_pin,
  output logic ack_pin,
  output logic sel_pin,
  output logic fault_pin
);

  localparam logic [FILT_LEN-1:0] ALL_HI = '1;

  logic                meta, sync;
  logic [FILT_LEN-1:0] hist;
  logic                blocked, sw_owns;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= 1'b1;
      sync <= 1'b1;
    end else begin
      meta <= selin_raw;
      sync <= meta;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hist       <= ALL_HI;
      selin_stat <= 1'b1;
    end else begin
      hist <= {hist[FILT_LEN-2:0], sync};
      if (!filt_en)          selin_stat <= sync;
      else if (hist == ALL_HI) selin_stat <= 1'b1;
      else if (hist == '0)   selin_stat <= 1'b0;
    end

  assign blocked = abort_en & ~selin_stat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       data_en <= 1'b0;
    else if (blocked) data_en <= 1'b0;
    else if (de_wr)   data_en <= de_wdata;

  assign pd_oe     = data_en & ~blocked;
  assign sw_owns   = ~hs_en & hs_idle;
  assign busy_pin  = sw_owns ? sw_busy : hs_busy;
  assign ack_pin   = sw_owns ? sw_ack  : hs_ack;
  assign sel_pin   = sw_sel;
  assign fault_pin = sw_fault;

endmodule

module pp_abort_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic abort_en,
  input logic de_wr,
  input logic de_wdata,
  input logic selin_stat,
  input logic data_en,
  input logic pd_oe,
  input logic sw_sel,
  input logic sel_pin
);

  assert_abort_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_en && !selin_stat) |=> !data_en);

  assert_tristate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_en || (abort_en && !selin_stat)) |-> !pd_oe);

  assert_write_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (de_wr && de_wdata && abort_en && !selin_stat) |=> !data_en);

  assert_set_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_en) |-> $past(de_wr && de_wdata));

  assert_sel_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pin == sw_sel);

endmodule

bind pp_abort_guard pp_abort_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .abort_en(abort_en), .de_wr(de_wr),
  .de_wdata(de_wdata), .selin_stat(selin_stat), .data_en(data_en),
  .pd_oe(pd_oe), .sw_sel(sw_sel), .sel_pin(sel_pin)
);

// File: tb/sim_pp_abort_guard.sv
module sim_pp_abort_guard;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic selin_raw = 1'b1, filt_en = 1'b0, abort_en = 1'b0;
  logic de_wr = 1'b0, de_wdata = 1'b0;
  logic sw_busy = 1'b0, sw_ack = 1'b0, sw_sel = 1'b0, sw_fault = 1'b0;
  logic hs_en = 1'b0, hs_idle = 1'b0, hs_busy = 1'b0, hs_ack = 1'b0;
  logic selin_stat, data_en, pd_oe, busy_pin, ack_pin, sel_pin, fault_pin;
  int errors = 0, checks = 0;

  always #(PERIOD/2) clk = ~clk;

  pp_abort_guard u0 (.*);

  // {hs_en,hs_idle,sw_busy,sw_ack,hs_busy,hs_ack,sw_sel,sw_fault, exp busy,ack,sel,fault}
  localparam logic [11:0] VEC [8] = '{
    12'b01_10_01_10_1010,
    12'b01_01_10_01_0101,
    12'b11_10_01_11_0111,
    12'b00_10_01_00_0100,
    12'b10_11_00_10_0010,
    12'b01_11_00_00_1100,
    12'b11_11_10_11_1011,
    12'b00_01_10_00_1000
  };

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic v);
    de_wr = 1'b1; de_wdata = v;
    step(1);
    de_wr = 1'b0;
  endtask

  initial begin
    #(PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(2);
    chk("R9 stat", selin_stat, 1'b1);
    chk("R9 data_en", data_en, 1'b0);
    chk("R9 pd_oe", pd_oe, 1'b0);
    rst_n = 1'b1;
    step(2);
    chk("R9 stat after", selin_stat, 1'b1);

    foreach (VEC[i]) begin
      {hs_en, hs_idle, sw_busy, sw_ack, hs_busy, hs_ack, sw_sel, sw_fault} = VEC[i][11:4];
      #1;
      chk("R7 busy", busy_pin, VEC[i][3]);
      chk("R7 ack", ack_pin, VEC[i][2]);
      chk("R8 sel", sel_pin, VEC[i][1]);
      chk("R8 fault", fault_pin, VEC[i][0]);
    end

    wr(1'b1);
    chk("R6 set", data_en, 1'b1);
    chk("R4 drive", pd_oe, 1'b1);
    wr(1'b0);
    chk("R6 clear", data_en, 1'b0);
    wr(1'b1);

    selin_raw = 1'b0;
    step(2);
    chk("R1 not yet", selin_stat, 1'b1);
    step(1);
    chk("R1 low at 3", selin_stat, 1'b0);
    step(2);
    chk("R5 no abort", data_en, 1'b1);

    abort_en = 1'b1;
    #1;
    chk("R4 same cycle", pd_oe, 1'b0);
    step(1);
    chk("R3 cleared", data_en, 1'b0);
    wr(1'b1);
    chk("R5 write ignored", data_en, 1'b0);
    chk("R4 off", pd_oe, 1'b0);

    selin_raw = 1'b1;
    step(3);
    chk("R1 high at 3", selin_stat, 1'b1);
    wr(1'b1);
    chk("R6 set again", data_en, 1'b1);

    filt_en = 1'b1;
    step(4);
    selin_raw = 1'b0;
    step(2);
    selin_raw = 1'b1;
    step(10);
    chk("R2 glitch dropped", selin_stat, 1'b1);
    chk("R2 data kept", data_en, 1'b1);

    selin_raw = 1'b0;
    step(5);
    chk("R2 not yet", selin_stat, 1'b1);
    step(1);
    chk("R2 low at 6", selin_stat, 1'b0);
    step(1);
    chk("R3 filtered abort", data_en, 1'b0);

    selin_raw = 1'b1;
    step(5);
    chk("R2 rise not yet", selin_stat, 1'b0);
    step(1);
    chk("R2 high at 6", selin_stat, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule